// File: doc/BRIEF.md
# Multi-Bank GPIO Interrupt Controller

This block is the pin-side half of a general purpose I/O controller whose pins are split into banks of up to 32 lanes. Each bank has its own eight-word register set. The set holds the output value and the direction, and it reports the synchronized input. It also sets up the interrupt behaviour of every pin in the bank. A flat word-addressed register port reaches all banks. The address bits above the low three pick the bank, and the low three pick the word inside it. Reads are combinational from the address.

Any pin can raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. Pending edge events stay latched until they are cleared by writing one to them. Level events track the pin. The masked pending bits of every bank combine into one interrupt line. A separate registered wake line reports each masked trigger as it happens, so an always-on domain can wake the system without reading status. The lane count of each bank is fixed at elaboration, and the lanes above it do nothing.

Top module: `gpio_multibank`

## Requirements
- R1: The registers of bank b sit at word addresses 8*b+0 to 8*b+7, in this order: synchronized input, output value, direction (1 = drive), interrupt mask (1 = enabled), interrupt status, trigger kind (1 = level), polarity (1 = falling or low), and any-edge enable. The output value, direction, mask, trigger kind, polarity and any-edge registers read back the last value written to them.
- R2: The input word shows each pin two clock edges after the pin changes, and not earlier. `pins_o` follows the output value register and `pins_oe_o` follows the direction register.
- R3: `irq_o` is high exactly when some bank has a status bit that is set while its mask bit is also set.
- R4: In edge mode (kind 0, any-edge 0) a status bit is set on a rising edge of the synchronized pin when polarity is 0, and on a falling edge when polarity is 1.
- R5: In edge mode with any-edge set to 1, both edges set the status bit, whatever the polarity bit holds.
- R6: An edge-mode status bit stays set until a 1 is written to it. Writing 0 to it has no effect. An edge that arrives in the same cycle as the clearing write leaves the bit set.
- R7: In level mode the status bit equals the registered trigger condition: a high pin when polarity is 0, a low pin when polarity is 1. A clearing write has no lasting effect while the condition holds, and the any-edge bit has no effect in level mode.
- R8: Lanes at or above a bank's configured width read as 0 in every register, ignore writes, and never set status, `irq_o` or `wake_o`.
- R9: `wake_o` is high for one cycle for each masked edge event, in the cycle its status bit sets. It stays high for as long as a masked level condition holds.
- R10: After reset all registers, `pins_o`, `pins_oe_o`, `irq_o` and `wake_o` are 0.
- R11: A bank index at or beyond the number of banks reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address: bank in the upper bits, register in bits [2:0] |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word (combinational) |
| pins_i | input | NUM_BANKS*32 | Pin inputs; lane k of bank b at bit 32*b+k |
| pins_o | output | NUM_BANKS*32 | Output values driven to the pads |
| pins_oe_o | output | NUM_BANKS*32 | Output enables driven to the pads |
| irq_o | output | 1 | Shared interrupt of all banks |
| wake_o | output | 1 | Registered wake indication |

## Verification
The hardest case to reach is an edge event that is committed on the same clock edge as a write that clears its status bit. Here the event has to win. The stimulus raises the pin on a falling clock edge and waits exactly two rising edges, so that the edge is visible after the synchronizer. It then starts the clearing write so that the write commits on the third edge, together with the event. The rest of the bench sweeps every lane of both banks, including the dead lanes, through all five trigger modes. The expected status, interrupt and wake values come from the mode table.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned LANES_MAX  = 32;
   localparam int unsigned BANK_WORDS = 8;
   localparam int unsigned WIDTH_BITS = 6;

   typedef enum logic [2:0] {
      REG_DIN  = 3'd0,
      REG_DOUT = 3'd1,
      REG_DIR  = 3'd2,
      REG_MASK = 3'd3,
      REG_STAT = 3'd4,
      REG_KIND = 3'd5,
      REG_POL  = 3'd6,
      REG_ANY  = 3'd7
   } gpio_reg_e;

   function automatic logic [LANES_MAX-1:0] live_lanes(input int unsigned width);
      logic [LANES_MAX-1:0] m;
      m = '0;
      for (int i = 0; i < LANES_MAX; i++) begin
         if (i < int'(width)) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
   import gpio_bank_pkg::*;
#(
   parameter logic [LANES_MAX-1:0] LIVE = '1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [LANES_MAX-1:0] pin_i,
   output logic [LANES_MAX-1:0] sync_o,
   output logic [LANES_MAX-1:0] rise_o,
   output logic [LANES_MAX-1:0] fall_o
);

   logic [LANES_MAX-1:0] meta_q, sync_q, prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= pin_i & LIVE;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   assign sync_o = sync_q;
   assign rise_o = sync_q & ~prev_q;
   assign fall_o = ~sync_q & prev_q;

   // R4: a detected rise needs the pin high two edges earlier
   p_rise_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((rise_o & ~$past(pin_i, 2)) == '0));

   // R4: a detected fall needs the pin low two edges earlier
   p_fall_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((fall_o & $past(pin_i, 2)) == '0));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_i,
   input  logic [2:0]           word_i,
   input  logic [31:0]          wdata_i,
   input  logic [LANES_MAX-1:0] sync_i,
   input  logic [LANES_MAX-1:0] rise_i,
   input  logic [LANES_MAX-1:0] fall_i,
   output logic [31:0]          rdata_o,
   output logic [LANES_MAX-1:0] dout_o,
   output logic [LANES_MAX-1:0] dir_o,
   output logic                 pend_o,
   output logic                 wake_hit_o
);

   localparam logic [LANES_MAX-1:0] LIVE = live_lanes(WIDTH);

   gpio_reg_e word;
   assign word = gpio_reg_e'(word_i);

   logic [LANES_MAX-1:0] dout_q, dir_q, mask_q, stat_q, kind_q, pol_q, any_q;
   logic [LANES_MAX-1:0] edge_ev, lvl_on, clr, stat_d, wval;
   logic                 wr_stat;

   assign wval    = wdata_i & LIVE;
   assign wr_stat = wr_i && (word == REG_STAT);
   assign clr     = wr_stat ? wval : '0;

   // edge events chosen per lane by polarity and any-edge enable
   assign edge_ev = LIVE & ~kind_q &
                    ((rise_i & (any_q | ~pol_q)) | (fall_i & (any_q | pol_q)));
   // level condition: polarity inverts the synchronized pin
   assign lvl_on  = LIVE & kind_q & (pol_q ^ sync_i);

   assign stat_d  = LIVE & (lvl_on | (~kind_q & ((stat_q & ~clr) | edge_ev)));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         dout_q <= '0;
         dir_q  <= '0;
         mask_q <= '0;
         stat_q <= '0;
         kind_q <= '0;
         pol_q  <= '0;
         any_q  <= '0;
      end else begin
         stat_q <= stat_d;
         if (wr_i) begin
            case (word)
               REG_DOUT: dout_q <= wval;
               REG_DIR:  dir_q  <= wval;
               REG_MASK: mask_q <= wval;
               REG_KIND: kind_q <= wval;
               REG_POL:  pol_q  <= wval;
               REG_ANY:  any_q  <= wval;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      case (word)
         REG_DIN:  rdata_o = sync_i & LIVE;
         REG_DOUT: rdata_o = dout_q;
         REG_DIR:  rdata_o = dir_q;
         REG_MASK: rdata_o = mask_q;
         REG_STAT: rdata_o = stat_q;
         REG_KIND: rdata_o = kind_q;
         REG_POL:  rdata_o = pol_q;
         REG_ANY:  rdata_o = any_q;
         default:  rdata_o = '0;
      endcase
   end

   assign dout_o     = dout_q;
   assign dir_o      = dir_q;
   assign pend_o     = |(stat_q & mask_q);
   assign wake_hit_o = |((edge_ev | lvl_on) & mask_q);

   // R6: an edge event always leaves its status bit set, even against a clear
   p_edge_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|edge_ev) |=> ((stat_q & $past(edge_ev)) == $past(edge_ev)));

   // R6: a write of ones clears edge-mode bits when no event competes
   p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stat && (edge_ev == '0)) |=> ((stat_q & $past(wval & ~kind_q)) == '0));

endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned                        NUM_BANKS   = 2,
   parameter logic [NUM_BANKS*WIDTH_BITS-1:0]    BANK_WIDTHS = {6'd4, 6'd8},
   parameter int unsigned                        ADDR_W      = 6
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic                        wr_en_i,
   input  logic [31:0]                 wdata_i,
   output logic [31:0]                 rdata_o,
   input  logic [NUM_BANKS*32-1:0]     pins_i,
   output logic [NUM_BANKS*32-1:0]     pins_o,
   output logic [NUM_BANKS*32-1:0]     pins_oe_o,
   output logic                        irq_o,
   output logic                        wake_o
);

   localparam int unsigned BSEL_W = ADDR_W - 3;

   if (NUM_BANKS < 1) begin : g_err_banks
      $error("gpio_multibank: NUM_BANKS must be at least 1");
   end
   if (BSEL_W < $clog2(NUM_BANKS) || ADDR_W < 4) begin : g_err_addr
      $error("gpio_multibank: ADDR_W too narrow for the bank count");
   end

   logic [BSEL_W-1:0]  bank_f;
   logic [2:0]         word_f;
   logic [31:0]        bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_pend, bank_wake;
   logic               wake_q;

   assign bank_f = addr_i[ADDR_W-1:3];
   assign word_f = addr_i[2:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned W = int'(BANK_WIDTHS[b*WIDTH_BITS +: WIDTH_BITS]);
      localparam logic [LANES_MAX-1:0] LIVE = live_lanes(W);

      if (W < 1 || W > LANES_MAX) begin : g_err_width
         $error("gpio_multibank: bank width outside 1..32");
      end

      logic [LANES_MAX-1:0] sync_w, rise_w, fall_w;
      logic                 wr_sel;

      assign wr_sel = wr_en_i && (bank_f == BSEL_W'(b));

      gpio_pin_sync #(.LIVE(LIVE)) u_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .pin_i  (pins_i[b*32 +: 32]),
         .sync_o (sync_w),
         .rise_o (rise_w),
         .fall_o (fall_w)
      );

      gpio_bank_regs #(.WIDTH(W)) u_regs (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .wr_i       (wr_sel),
         .word_i     (word_f),
         .wdata_i    (wdata_i),
         .sync_i     (sync_w),
         .rise_i     (rise_w),
         .fall_i     (fall_w),
         .rdata_o    (bank_rd[b]),
         .dout_o     (pins_o[b*32 +: 32]),
         .dir_o      (pins_oe_o[b*32 +: 32]),
         .pend_o     (bank_pend[b]),
         .wake_hit_o (bank_wake[b])
      );
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
         if (bank_f == BSEL_W'(b)) rdata_o = bank_rd[b];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) wake_q <= 1'b0;
      else         wake_q <= |bank_wake;
   end

   assign irq_o  = |bank_pend;
   assign wake_o = wake_q;

endmodule

// File: tb/gpio_multibank_tb_top.sv
module gpio_multibank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 2;
   localparam int AW = 6;
   localparam int BW [NB] = '{8, 4};

   // per-mode settings and expected bit values, bit m = mode m
   // modes: 0 rise, 1 fall, 2 any edge (polarity 1), 3 high level (any set), 4 low level
   localparam logic [4:0] M_KIND  = 5'b11000;
   localparam logic [4:0] M_POL   = 5'b10110;
   localparam logic [4:0] M_ANY   = 5'b01100;
   localparam logic [4:0] E_RISE  = 5'b01101;
   localparam logic [4:0] W_RISE  = 5'b01101;
   localparam logic [4:0] W_HOLD  = 5'b01000;
   localparam logic [4:0] E_FALL  = 5'b10111;
   localparam logic [4:0] W_FALL  = 5'b10110;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic            wr_en = 1'b0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NB*32-1:0] pins = '0;
   logic [NB*32-1:0] pins_o, pins_oe;
   logic            irq, wake;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_multibank #(.NUM_BANKS(NB), .BANK_WIDTHS({6'd4, 6'd8}), .ADDR_W(AW)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_en_i (wr_en),
      .wdata_i (wdata), .rdata_o (rdata), .pins_i (pins), .pins_o (pins_o),
      .pins_oe_o (pins_oe), .irq_o (irq), .wake_o (wake)
   );

   function automatic logic [31:0] live(input int b);
      return (BW[b] >= 32) ? 32'hFFFF_FFFF : ((32'd1 << BW[b]) - 32'd1);
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      addr = AW'(a); wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      step(4);
      rst_n = 1'b1;
      step(1);

      // R10: reset state
      for (int b = 0; b < NB; b++)
         for (int r = 0; r < 8; r++) begin
            rd(b*8 + r, d);
            check(d, 32'h0, "R10 register after reset");
         end
      check({31'b0, irq}, 32'h0, "R10 irq after reset");
      check({31'b0, wake}, 32'h0, "R10 wake after reset");
      check(pins_o[31:0] | pins_o[63:32] | pins_oe[31:0] | pins_oe[63:32], 32'h0, "R10 pad outputs");

      // R1 / R8: write every writable word, then read all back
      for (int b = 0; b < NB; b++)
         for (int r = 1; r < 8; r++)
            if (r != 4) wr(b*8 + r, 32'h9E37_79B9 * (b*8 + r + 1));
      for (int b = 0; b < NB; b++)
         for (int r = 1; r < 8; r++)
            if (r != 4) begin
               rd(b*8 + r, d);
               check(d, (32'h9E37_79B9 * (b*8 + r + 1)) & live(b), "R1 R8 readback");
            end
      // R2: pad outputs follow output and direction words
      check(pins_o[31:0], (32'h9E37_79B9 * 2) & live(0), "R2 pins_o bank0");
      check(pins_oe[63:32], (32'h9E37_79B9 * 11) & live(1), "R2 pins_oe bank1");

      // R11: out-of-range banks read zero and change nothing
      for (int b = NB; b < 8; b++) begin
         wr(b*8 + 3, 32'hFFFF_FFFF);
         rd(b*8 + 3, d);
         check(d, 32'h0, "R11 out-of-range read");
      end
      for (int b = 0; b < NB; b++) begin
         rd(b*8 + 3, d);
         check(d, (32'h9E37_79B9 * (b*8 + 4)) & live(b), "R11 no alias write");
      end

      // restore: all config zero, then clear status
      for (int b = 0; b < NB; b++) begin
         for (int r = 1; r < 8; r++) if (r != 4) wr(b*8 + r, 32'h0);
         wr(b*8 + 4, 32'hFFFF_FFFF);
         rd(b*8 + 4, d);
         check(d, 32'h0, "R6 status cleared by write of ones");
      end

      // R2: two-stage input synchronization
      pins = {32'hDEAD_BEEF, 32'h1234_5678};
      step(1);
      rd(0, d); check(d, 32'h0, "R2 input not yet visible after one edge");
      step(1);
      rd(0, d); check(d, 32'h1234_5678 & live(0), "R2 input bank0");
      rd(8, d); check(d, 32'hDEAD_BEEF & live(1), "R2 input bank1 with R8 dead lanes");
      pins = '0;
      step(3);

      // R4 R5 R7 R9 R3: sweep every live lane of every bank through five modes
      for (int b = 0; b < NB; b++)
         for (int k = 0; k < BW[b]; k++)
            for (int m = 0; m < 5; m++) begin
               logic [31:0] bit_k;
               bit_k = 32'd1 << k;
               wr(b*8 + 6, M_POL[m]  ? 32'hFFFF_FFFF : 32'h0);
               wr(b*8 + 7, M_ANY[m]  ? 32'hFFFF_FFFF : 32'h0);
               wr(b*8 + 5, M_KIND[m] ? 32'hFFFF_FFFF : 32'h0);
               wr(b*8 + 3, bit_k);
               step(2);
               wr(b*8 + 4, 32'hFFFF_FFFF);
               rd(b*8 + 4, d);
               check(d, (m == 4) ? live(b) : 32'h0, "R7 status after clear attempt");
               check({31'b0, irq}, {31'b0, m == 4}, "R3 irq idle");
               // rising pin
               pins[b*32 + k] = 1'b1;
               step(3);
               rd(b*8 + 4, d);
               check(d, (m == 4) ? (live(b) & ~bit_k) : (E_RISE[m] ? bit_k : 32'h0), "R4 R5 R7 status after rise");
               check({31'b0, irq}, {31'b0, E_RISE[m]}, "R3 irq after rise");
               check({31'b0, wake}, {31'b0, W_RISE[m]}, "R9 wake after rise");
               step(1);
               check({31'b0, wake}, {31'b0, W_HOLD[m]}, "R9 wake one cycle later");
               // falling pin
               pins[b*32 + k] = 1'b0;
               step(3);
               rd(b*8 + 4, d);
               check(d, (m == 4) ? live(b) : (E_FALL[m] ? bit_k : 32'h0), "R4 R5 R6 R7 status after fall");
               check({31'b0, irq}, {31'b0, E_FALL[m]}, "R3 irq after fall");
               check({31'b0, wake}, {31'b0, W_FALL[m]}, "R9 wake after fall");
               // cleanup
               wr(b*8 + 5, 32'h0);
               wr(b*8 + 6, 32'h0);
               wr(b*8 + 7, 32'h0);
               wr(b*8 + 3, 32'h0);
               wr(b*8 + 4, 32'hFFFF_FFFF);
            end

      // R8: dead lanes never raise anything
      wr(3, 32'hFFFF_FFFF);
      wr(8 + 3, 32'hFFFF_FFFF);
      pins[20] = 1'b1;
      pins[32 + 6] = 1'b1;
      step(3);
      rd(4, d);      check(d, 32'h0, "R8 bank0 dead lane status");
      rd(8 + 4, d);  check(d, 32'h0, "R8 bank1 dead lane status");
      rd(8 + 0, d);  check(d, 32'h0, "R8 bank1 dead lane input");
      check({31'b0, irq}, 32'h0, "R8 irq quiet");
      check({31'b0, wake}, 32'h0, "R8 wake quiet");
      pins = '0;
      wr(3, 32'h1);
      wr(8 + 3, 32'h0);
      step(3);

      // R6: sticky, zero write ignored, event beats clear
      pins[0] = 1'b1;
      step(3);
      wr(4, 32'h0);
      rd(4, d); check(d, 32'h1, "R6 zero write leaves bit set");
      wr(4, 32'h1);
      rd(4, d); check(d, 32'h0, "R6 one write clears bit");
      pins[0] = 1'b0;
      step(3);
      pins[0] = 1'b1;
      step(2);
      wr(4, 32'h1);
      rd(4, d); check(d, 32'h1, "R6 edge wins over same-cycle clear");
      check({31'b0, irq}, 32'h1, "R3 irq with coincident clear");
      wr(4, 32'h1);
      rd(4, d); check(d, 32'h0, "R6 cleared afterwards");
      check({31'b0, irq}, 32'h0, "R3 irq released");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule